// File: doc/BRIEF.md
# ALU with Status-Flag Register

This block is the 8-bit arithmetic and logic datapath of a small controller core, paired with the 8-bit status register that records its flags. Each cycle it takes an operation code and two operands: `opa` on the accumulator side and `opb` on the memory side. It returns the result and a zero indication on the same cycle, with no register in that path. The zero indication can drive skip decisions. On the next rising clock edge the status register takes the flags that the operation is defined to change. The sequencer may write the status register directly. That write can change only the four arithmetic flags.

The two remaining flags record power-down and watchdog time-out. Only event strobes change them: power-up, watchdog clear, halt entry and watchdog expiry. A strobe that clears a flag beats a strobe that sets it in the same cycle. The sequencer supplies the operands; instruction sequencing is handled elsewhere.

Top module: `alu_status_unit`

## Requirements
- R1: The status byte is laid out as C at bit 0, AC at bit 1, Z at bit 2, OV at bit 3, PD at bit 4 and TO at bit 5. Bits 7 and 6 always read 0. A synchronous reset clears the whole byte to 00h.
- R2: ADD (opcode 1) returns opa+opb, and ADC (opcode 2) returns opa+opb+C. Both update all four arithmetic flags. C is the carry out of bit 7 and AC is the carry out of bit 3. OV is set when the signed sum leaves the range -128..127. Z is set when the result is 0.
- R3: SUB (opcode 3) returns opa-opb, and SBC (opcode 4) returns opa-opb-(1-C). C is set when no borrow occurs, meaning opa is at least opb plus the borrow-in. AC is set when no borrow leaves the low nibble. OV is set when the signed difference leaves -128..127. Z is set on a zero result. All four flags update.
- R4: DAA (opcode 5) first adds 06h to opa when its low nibble exceeds 9 or AC is 1. It then adds 60h when the high nibble of that intermediate value exceeds 9 or C is 1. The new C is the old C ORed with the carry of either step. No other flag changes.
- R5: AND (6), OR (7) and XOR (8) combine opa with opb. CPL (9) inverts opa, INC (14) adds 1 to opa and DEC (15) subtracts 1 from opa. Each of these six writes Z from its result and leaves C, AC and OV unchanged.
- R6: RL (10) rotates opa left and RR (11) rotates it right; neither changes any flag. RLC (12) shifts C into bit 0 and moves bit 7 into C. RRC (13) shifts C into bit 7 and moves bit 0 into C. RLC and RRC change no other flag.
- R7: `result` and `zero` are combinational. `zero` is 1 exactly when `result` is 00h, for every opcode.
- R8: A status write (`stat_we`) loads bits 3..0 from `stat_wdata` on the next edge. If an operation that updates flags falls in the same cycle, the write wins. Data bits 7..4 are ignored, so PD and TO keep their values.
- R9: PD is cleared by power-up or watchdog clear and set by halt. When a clear and halt arrive in the same cycle, the clear wins.
- R10: TO is cleared by power-up, watchdog clear or halt, and set by watchdog time-out. When any of these clears arrives in the same cycle as a time-out, the clear wins.
- R11: NOP (opcode 0) passes opa to `result` and changes no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| opcode | input | 4 | Operation select (encodings in the requirements) |
| opa | input | 8 | Accumulator-side operand |
| opb | input | 8 | Memory-side operand |
| stat_we | input | 1 | Status register write strobe |
| stat_wdata | input | 8 | Status write data; only bits 3..0 are used |
| ev_powerup | input | 1 | Power-up event strobe |
| ev_wdt_clr | input | 1 | Watchdog-clear event strobe |
| ev_halt | input | 1 | Halt-entry event strobe |
| ev_wdt_tmo | input | 1 | Watchdog time-out event strobe |
| result | output | 8 | Operation result, combinational |
| zero | output | 1 | High when result is zero (skip indication) |
| status | output | 8 | Status register contents |

## Verification
Two pairs of functions can fall on the same edge. The first pair is a software status write and a flag update from the operation on the same cycle. The bench provokes it by asserting `stat_wdata` together with ADD and SUB operand pairs chosen to produce every flag. It judges the outcome by requiring the low status nibble to equal the written data and not the computed flags. The second pair is a clearing event and a setting event on the PD/TO pair. The bench applies all sixteen combinations of the four strobes from each of the four starting states of PD and TO, with a status write in the same cycle. It requires the clearing event to win and requires the written data to leave both flags as they were.

// File: rtl/alu_pkg.sv
package alu_pkg;

    localparam int DATA_W = 8;
    localparam int NIB_W  = DATA_W / 2;
    localparam int NFLAG  = 4;

    // positions inside the status byte
    localparam int FLG_C  = 0;
    localparam int FLG_AC = 1;
    localparam int FLG_Z  = 2;
    localparam int FLG_OV = 3;
    localparam int FLG_PD = 4;
    localparam int FLG_TO = 5;

    typedef enum logic [3:0] {
        OP_NOP = 4'd0,
        OP_ADD = 4'd1,
        OP_ADC = 4'd2,
        OP_SUB = 4'd3,
        OP_SBC = 4'd4,
        OP_DAA = 4'd5,
        OP_AND = 4'd6,
        OP_OR  = 4'd7,
        OP_XOR = 4'd8,
        OP_CPL = 4'd9,
        OP_RL  = 4'd10,
        OP_RR  = 4'd11,
        OP_RLC = 4'd12,
        OP_RRC = 4'd13,
        OP_INC = 4'd14,
        OP_DEC = 4'd15
    } alu_op_e;

    // the four flags an operation may touch, in status order
    typedef struct packed {
        logic ov;
        logic z;
        logic ac;
        logic c;
    } arith_flags_t;

    typedef struct packed {
        logic [1:0] rsvd;
        logic       to;
        logic       pd;
        logic       ov;
        logic       z;
        logic       ac;
        logic       c;
    } status_t;

    typedef struct packed {
        logic pwr_up;
        logic wdt_clr;
        logic halt;
        logic wdt_tmo;
    } sys_events_t;

    // which arithmetic flags an opcode is allowed to write
    function automatic arith_flags_t flag_mask(input alu_op_e op);
        arith_flags_t m;
        m = '0;
        unique case (op)
            OP_ADD, OP_ADC, OP_SUB, OP_SBC: m = '{ov: 1'b1, z: 1'b1, ac: 1'b1, c: 1'b1};
            OP_DAA, OP_RLC, OP_RRC:         m.c = 1'b1;
            OP_AND, OP_OR, OP_XOR,
            OP_CPL, OP_INC, OP_DEC:         m.z = 1'b1;
            default:                        m = '0;
        endcase
        return m;
    endfunction

    function automatic logic uses_addsub(input alu_op_e op);
        return (op == OP_ADD) || (op == OP_ADC) || (op == OP_SUB) || (op == OP_SBC);
    endfunction

endpackage

// File: rtl/alu_addsub.sv
module alu_addsub
    import alu_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         sub,
    input  logic         cin,
    output logic [W-1:0] res,
    output logic         c_out,
    output logic         ac_out,
    output logic         ov_out
);
    localparam int NIB = W / 2;

    logic [W-1:0] bx;
    logic [NIB:0] lo_sum;
    logic [W-1:0] top_in_sum;
    logic [W:0]   full_sum;

    // subtraction runs as a + ~b + cin, so every carry reads as "no borrow"
    assign bx         = sub ? ~b : b;
    assign lo_sum     = {1'b0, a[NIB-1:0]} + {1'b0, bx[NIB-1:0]} + {{NIB{1'b0}}, cin};
    assign top_in_sum = {1'b0, a[W-2:0]} + {1'b0, bx[W-2:0]} + {{(W-1){1'b0}}, cin};
    assign full_sum   = {1'b0, a} + {1'b0, bx} + {{W{1'b0}}, cin};

    assign res    = full_sum[W-1:0];
    assign c_out  = full_sum[W];
    assign ac_out = lo_sum[NIB];
    assign ov_out = full_sum[W] ^ top_in_sum[W-1];

endmodule

// File: rtl/alu_daa.sv
module alu_daa
    import alu_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic [W-1:0] a,
    input  logic         c_in,
    input  logic         ac_in,
    output logic [W-1:0] res,
    output logic         c_out
);
    localparam int NIB = W / 2;
    localparam logic [NIB-1:0] DIGIT_MAX = NIB'(9);
    localparam logic [W:0]     LO_FIX    = (W+1)'(6);
    localparam logic [W:0]     HI_FIX    = (W+1)'(6) << NIB;

    logic       adj_lo;
    logic       adj_hi;
    logic [W:0] step1;
    logic [W:0] step2;

    assign adj_lo = (a[NIB-1:0] > DIGIT_MAX) || ac_in;
    assign step1  = {1'b0, a} + (adj_lo ? LO_FIX : '0);
    assign adj_hi = (step1[W-1:NIB] > DIGIT_MAX) || c_in;
    assign step2  = {1'b0, step1[W-1:0]} + (adj_hi ? HI_FIX : '0);

    assign res   = step2[W-1:0];
    assign c_out = c_in | step1[W] | step2[W];

endmodule

// File: rtl/alu_bitops.sv
module alu_bitops
    import alu_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  alu_op_e      op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    output logic [W-1:0] res,
    output logic         c_out
);
    always_comb begin
        res   = a;
        c_out = cin;
        unique case (op)
            OP_AND: res = a & b;
            OP_OR:  res = a | b;
            OP_XOR: res = a ^ b;
            OP_CPL: res = ~a;
            OP_INC: res = a + W'(1);
            OP_DEC: res = a - W'(1);
            OP_RL:  res = {a[W-2:0], a[W-1]};
            OP_RR:  res = {a[0], a[W-1:1]};
            OP_RLC: begin
                res   = {a[W-2:0], cin};
                c_out = a[W-1];
            end
            OP_RRC: begin
                res   = {cin, a[W-1:1]};
                c_out = a[0];
            end
            default: res = a;
        endcase
    end

endmodule

// File: rtl/alu_status_reg.sv
module alu_status_reg
    import alu_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  arith_flags_t upd_mask,
    input  arith_flags_t upd_val,
    input  logic         wr_en,
    input  arith_flags_t wr_val,
    input  sys_events_t  ev,
    output status_t      st
);
    logic [NFLAG-1:0] cur_f;
    logic [NFLAG-1:0] nxt_f;
    logic             pd_q;
    logic             to_q;
    logic             pd_d;
    logic             to_d;

    // per flag: software write, else ALU update when masked in, else hold
    for (genvar i = 0; i < NFLAG; i++) begin : g_flag
        assign nxt_f[i] = wr_en       ? wr_val[i]  :
                          upd_mask[i] ? upd_val[i] : cur_f[i];
    end

    // clearing events take priority over setting events
    always_comb begin
        pd_d = pd_q;
        if (ev.pwr_up || ev.wdt_clr) pd_d = 1'b0;
        else if (ev.halt)            pd_d = 1'b1;

        to_d = to_q;
        if (ev.pwr_up || ev.wdt_clr || ev.halt) to_d = 1'b0;
        else if (ev.wdt_tmo)                    to_d = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_f <= '0;
            pd_q  <= 1'b0;
            to_q  <= 1'b0;
        end else begin
            cur_f <= nxt_f;
            pd_q  <= pd_d;
            to_q  <= to_d;
        end
    end

    always_comb begin
        st      = '0;
        st.c    = cur_f[FLG_C];
        st.ac   = cur_f[FLG_AC];
        st.z    = cur_f[FLG_Z];
        st.ov   = cur_f[FLG_OV];
        st.pd   = pd_q;
        st.to   = to_q;
    end

endmodule

// File: rtl/alu_status_unit.sv
module alu_status_unit
    import alu_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic [3:0]          opcode,
    input  logic [DATA_W-1:0]   opa,
    input  logic [DATA_W-1:0]   opb,
    input  logic                stat_we,
    input  logic [DATA_W-1:0]   stat_wdata,
    input  logic                ev_powerup,
    input  logic                ev_wdt_clr,
    input  logic                ev_halt,
    input  logic                ev_wdt_tmo,
    output logic [DATA_W-1:0]   result,
    output logic                zero,
    output logic [DATA_W-1:0]   status
);
    alu_op_e      op;
    status_t      st;
    arith_flags_t mask;
    arith_flags_t vals;
    arith_flags_t wr_flags;
    sys_events_t  evs;

    logic [DATA_W-1:0] as_res;
    logic              as_c, as_ac, as_ov, as_sub, as_cin;
    logic [DATA_W-1:0] daa_res;
    logic              daa_c;
    logic [DATA_W-1:0] bo_res;
    logic              bo_c;
    logic              wdata_unused;

    assign op = alu_op_e'(opcode);

    assign as_sub = (op == OP_SUB) || (op == OP_SBC);
    assign as_cin = (op == OP_ADD) ? 1'b0 :
                    (op == OP_SUB) ? 1'b1 : st.c;

    alu_addsub #(.W(DATA_W)) u_addsub (
        .a      (opa),
        .b      (opb),
        .sub    (as_sub),
        .cin    (as_cin),
        .res    (as_res),
        .c_out  (as_c),
        .ac_out (as_ac),
        .ov_out (as_ov)
    );

    alu_daa #(.W(DATA_W)) u_daa (
        .a     (opa),
        .c_in  (st.c),
        .ac_in (st.ac),
        .res   (daa_res),
        .c_out (daa_c)
    );

    alu_bitops #(.W(DATA_W)) u_bitops (
        .op    (op),
        .a     (opa),
        .b     (opb),
        .cin   (st.c),
        .res   (bo_res),
        .c_out (bo_c)
    );

    always_comb begin
        if (uses_addsub(op))     result = as_res;
        else if (op == OP_DAA)   result = daa_res;
        else                     result = bo_res;
    end

    assign zero = (result == '0);
    assign mask = flag_mask(op);

    always_comb begin
        vals.z  = zero;
        vals.ov = as_ov;
        vals.ac = as_ac;
        if (uses_addsub(op))   vals.c = as_c;
        else if (op == OP_DAA) vals.c = daa_c;
        else                   vals.c = bo_c;
    end

    assign wr_flags     = arith_flags_t'(stat_wdata[NFLAG-1:0]);
    assign wdata_unused = ^stat_wdata[DATA_W-1:NFLAG];
    assign evs          = '{pwr_up: ev_powerup, wdt_clr: ev_wdt_clr,
                            halt: ev_halt, wdt_tmo: ev_wdt_tmo};

    alu_status_reg u_status (
        .clk      (clk),
        .rst      (rst),
        .upd_mask (mask),
        .upd_val  (vals),
        .wr_en    (stat_we),
        .wr_val   (wr_flags),
        .ev       (evs),
        .st       (st)
    );

    assign status = st;

endmodule

// File: rtl/alu_status_chk.sv
module alu_status_chk (
    input logic       clk,
    input logic       rst,
    input logic [3:0] opcode,
    input logic       stat_we,
    input logic [7:0] stat_wdata,
    input logic       ev_powerup,
    input logic       ev_wdt_clr,
    input logic       ev_halt,
    input logic       ev_wdt_tmo,
    input logic       zero,
    input logic [7:0] status
);
    p_rsvd_zero_r1: assert property (@(posedge clk) disable iff (rst)
        status[7:6] == 2'b00);

    p_add_zero_r2: assert property (@(posedge clk) disable iff (rst)
        (opcode == 4'd1 && !stat_we) |=> status[2] == $past(zero));

    p_logic_z_only_r5: assert property (@(posedge clk) disable iff (rst)
        ((opcode == 4'd6 || opcode == 4'd9 || opcode == 4'd14) && !stat_we)
        |=> (status[2] == $past(zero)) && (status[3] == $past(status[3]))
            && (status[1:0] == $past(status[1:0])));

    p_plain_rotate_r6: assert property (@(posedge clk) disable iff (rst)
        ((opcode == 4'd10 || opcode == 4'd11) && !stat_we) |=> $stable(status[3:0]));

    p_write_wins_r8: assert property (@(posedge clk) disable iff (rst)
        stat_we |=> status[3:0] == $past(stat_wdata[3:0]));

    p_write_keeps_sys_r8: assert property (@(posedge clk) disable iff (rst)
        (stat_we && !ev_powerup && !ev_wdt_clr && !ev_halt && !ev_wdt_tmo)
        |=> status[5:4] == $past(status[5:4]));

    p_halt_sets_pd_r9: assert property (@(posedge clk) disable iff (rst)
        (ev_halt && !ev_powerup && !ev_wdt_clr) |=> status[4]);

    p_clear_pd_r9: assert property (@(posedge clk) disable iff (rst)
        (ev_powerup || ev_wdt_clr) |=> !status[4]);

    p_clear_beats_tmo_r10: assert property (@(posedge clk) disable iff (rst)
        (ev_powerup || ev_wdt_clr || ev_halt) |=> !status[5]);

    p_tmo_sets_to_r10: assert property (@(posedge clk) disable iff (rst)
        (ev_wdt_tmo && !ev_powerup && !ev_wdt_clr && !ev_halt) |=> status[5]);

    p_nop_holds_r11: assert property (@(posedge clk) disable iff (rst)
        (opcode == 4'd0 && !stat_we) |=> $stable(status[3:0]));

endmodule

bind alu_status_unit alu_status_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .opcode     (opcode),
    .stat_we    (stat_we),
    .stat_wdata (stat_wdata),
    .ev_powerup (ev_powerup),
    .ev_wdt_clr (ev_wdt_clr),
    .ev_halt    (ev_halt),
    .ev_wdt_tmo (ev_wdt_tmo),
    .zero       (zero),
    .status     (status)
);

// File: tb/sim_alu_status_unit.sv
module sim_alu_status_unit;

    localparam int C_NOP = 0, C_ADD = 1, C_ADC = 2, C_SUB = 3, C_SBC = 4, C_DAA = 5;
    localparam int C_AND = 6, C_OR = 7, C_XOR = 8, C_CPL = 9, C_RL = 10, C_RR = 11;
    localparam int C_RLC = 12, C_RRC = 13, C_INC = 14, C_DEC = 15;

    logic       clk = 1'b0;
    logic       rst;
    logic [3:0] opcode;
    logic [7:0] opa, opb, stat_wdata;
    logic       stat_we, ev_powerup, ev_wdt_clr, ev_halt, ev_wdt_tmo;
    logic [7:0] result, status;
    logic       zero;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    always #5 clk = ~clk;

    alu_status_unit u0 (
        .clk(clk), .rst(rst), .opcode(opcode), .opa(opa), .opb(opb),
        .stat_we(stat_we), .stat_wdata(stat_wdata),
        .ev_powerup(ev_powerup), .ev_wdt_clr(ev_wdt_clr),
        .ev_halt(ev_halt), .ev_wdt_tmo(ev_wdt_tmo),
        .result(result), .zero(zero), .status(status)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s op=%0d a=%02h b=%02h act=%02h exp=%02h",
                     req, opcode, opa, opb, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic idle();
        opcode = 4'd0; stat_we = 0; stat_wdata = 8'h00;
        ev_powerup = 0; ev_wdt_clr = 0; ev_halt = 0; ev_wdt_tmo = 0;
    endtask

    // load the four arithmetic flags, PD/TO untouched
    task automatic preload(input int flags);
        idle();
        stat_we = 1; stat_wdata = 8'(flags);
        tick();
        stat_we = 0;
    endtask

    // apply one operation: result/zero checked mid-cycle, status after the edge
    task automatic run_op(input string req, input int op, input int a, input int b,
                          input int exp_res, input int exp_stat);
        opcode = 4'(op); opa = 8'(a); opb = 8'(b);
        #4;
        chk(req, int'(result), exp_res);
        chk("R7", int'(zero), (exp_res == 0) ? 1 : 0);
        tick();
        chk(req, int'(status), exp_stat);
    endtask

    task automatic arith_case(input int op, input int a, input int b, input int cin, input int pre);
        int r, c, ac, ov, z, bin, sa, sb, sr;
        string req;
        sa = (a > 127) ? a - 256 : a;
        sb = (b > 127) ? b - 256 : b;
        if (op == C_ADD || op == C_ADC) begin
            req = "R2";
            bin = (op == C_ADC) ? cin : 0;
            r   = a + b + bin;
            c   = (r > 255) ? 1 : 0;
            ac  = ((a % 16) + (b % 16) + bin > 15) ? 1 : 0;
            sr  = sa + sb + bin;
        end else begin
            req = "R3";
            bin = (op == C_SBC) ? 1 - cin : 0;
            r   = (a - b - bin + 512) % 256;
            c   = (a >= b + bin) ? 1 : 0;
            ac  = ((a % 16) >= (b % 16) + bin) ? 1 : 0;
            sr  = sa - sb - bin;
        end
        r  = r % 256;
        ov = (sr > 127 || sr < -128) ? 1 : 0;
        z  = (r == 0) ? 1 : 0;
        preload(pre);
        run_op(req, op, a, b, r, ov * 8 + z * 4 + ac * 2 + c);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: run did not finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        idle(); opa = 0; opb = 0;
        rst = 1;
        tick(); tick();
        // R1: reset value, checked while still in reset and after release
        chk("R1", int'(status), 0);
        rst = 0;
        opa = 8'h00;
        #4;
        chk("R11", int'(result), 0);
        chk("R7", int'(zero), 1);
        tick();
        chk("R1", int'(status), 0);

        // R1 / R8: writing all ones sets only the four arithmetic flags
        stat_we = 1; stat_wdata = 8'hFF;
        tick();
        stat_we = 0;
        chk("R8", int'(status), 8'h0F);

        // R2 / R3: near-exhaustive add/subtract sweep
        for (int op = C_ADD; op <= C_SBC; op++)
            for (int a = 0; a < 256; a++)
                for (int j = 0; j < 16; j++) begin
                    int b, cin, pre;
                    b   = (j * 17 + a * 3) % 256;
                    cin = (j + a) % 2;
                    pre = 8'h0E | cin;
                    arith_case(op, a, b, cin, pre);
                end

        // R5 / R6 / R11: unary, logic and rotate forms, both carry-in values
        for (int op = C_NOP; op <= C_DEC; op++) begin
            if (op >= C_ADD && op <= C_DAA) continue;
            for (int a = 0; a < 256; a++)
                for (int cin = 0; cin < 2; cin++) begin
                    int b, pre, r, st;
                    string req;
                    b   = (a * 7 + 13) % 256;
                    pre = ((a / 2) % 2) * 8 + ((a / 4) % 2) * 4 + ((a / 8) % 2) * 2 + cin;
                    st  = pre;
                    case (op)
                        C_AND: r = a & b;
                        C_OR:  r = a | b;
                        C_XOR: r = a ^ b;
                        C_CPL: r = 255 - a;
                        C_INC: r = (a + 1) % 256;
                        C_DEC: r = (a + 255) % 256;
                        C_RL:  r = (a * 2) % 256 + a / 128;
                        C_RR:  r = a / 2 + (a % 2) * 128;
                        C_RLC: r = (a * 2) % 256 + cin;
                        C_RRC: r = a / 2 + cin * 128;
                        default: r = a;
                    endcase
                    if (op >= C_AND && op <= C_CPL || op == C_INC || op == C_DEC) begin
                        req = "R5";
                        st  = (pre & 8'h0B) | ((r == 0) ? 4 : 0);
                    end else if (op == C_RLC) begin
                        req = "R6";
                        st  = (pre & 8'h0E) | (a / 128);
                    end else if (op == C_RRC) begin
                        req = "R6";
                        st  = (pre & 8'h0E) | (a % 2);
                    end else if (op == C_RL || op == C_RR) begin
                        req = "R6";
                    end else begin
                        req = "R11";
                    end
                    preload(pre);
                    run_op(req, op, a, b, r, st);
                end
        end

        // R4: decimal adjust over every operand and both carry flags
        for (int a = 0; a < 256; a++)
            for (int f = 0; f < 4; f++) begin
                int c0, ac0, t, c1, c2, pre;
                c0  = f % 2;
                ac0 = f / 2;
                t   = a;
                if ((a % 16) > 9 || ac0 == 1) t = t + 6;
                c1  = (t > 255) ? 1 : 0;
                t   = t % 256;
                if ((t / 16) > 9 || c0 == 1) t = t + 96;
                c2  = (t > 255) ? 1 : 0;
                t   = t % 256;
                pre = 8'h0C | ac0 * 2 | c0;
                preload(pre);
                run_op("R4", C_DAA, a, 0, t, (pre & 8'h0E) | (c0 | c1 | c2));
            end

        // R8: status write collides with a flag-updating operation
        for (int k = 0; k < 16; k++) begin
            int a, b;
            a = (k * 37 + 128) % 256;
            b = (k * 91 + 128) % 256;
            idle();
            opcode = 4'((k % 2 == 0) ? C_ADD : C_SUB);
            opa = 8'(a); opb = 8'(b);
            stat_we = 1; stat_wdata = 8'(k * 16 + (15 - k));
            tick();
            chk("R8", int'(status), 15 - k);
        end

        // R9 / R10: every event combination from every PD/TO start state
        for (int init = 0; init < 4; init++)
            for (int e = 0; e < 16; e++) begin
                int pu, cl, hl, tm, pd, to, epd, eto, wd;
                idle(); ev_powerup = 1; tick();
                idle();
                if (init % 2 == 1) begin ev_halt = 1; tick(); idle(); end
                if (init / 2 == 1) begin ev_wdt_tmo = 1; tick(); idle(); end
                pd = init % 2; to = init / 2;
                chk("R9", int'(status[4]), pd);
                chk("R10", int'(status[5]), to);
                pu = e % 2; cl = (e / 2) % 2; hl = (e / 4) % 2; tm = e / 8;
                wd = (e * 16 + init * 5 + 3) % 256;
                ev_powerup = pu[0]; ev_wdt_clr = cl[0]; ev_halt = hl[0]; ev_wdt_tmo = tm[0];
                stat_we = 1; stat_wdata = 8'(wd);
                epd = (pu == 1 || cl == 1) ? 0 : (hl == 1) ? 1 : pd;
                eto = (pu == 1 || cl == 1 || hl == 1) ? 0 : (tm == 1) ? 1 : to;
                tick();
                idle();
                chk("R9", int'(status[4]), epd);
                chk("R10", int'(status[5]), eto);
                chk("R8", int'(status[3:0]), wd % 16);
                chk("R1", int'(status[7:6]), 0);
            end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule